// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block checks one memory access against a code or data segment and turns it into a linear address. Each request brings an unpacked eight-byte descriptor, a 32-bit offset, an access kind and a mode select. In protected mode the block works out the segment base, the effective limit and the permissions from the descriptor. In real mode it ignores the descriptor, takes the base as the 16-bit segment value shifted left by four, and uses a fixed 64K limit.

The result comes back one clock after the request strobe. It carries the linear address, a fault flag with a reason code, and a request to set the descriptor's accessed bit. The descriptor fetch, the write-back of the accessed bit, paging and privilege-ring comparison belong to the surrounding pipeline.

Top module: `seg_access_checker`

## Requirements
- R1: Outputs are registered. A request taken with `req_valid` high at one rising edge produces `rsp_valid` high after that edge. A cycle without a request produces `rsp_valid`, `fault` and `set_accessed` low after the next edge. Reset (synchronous, active high) clears every output. When `rsp_valid` is high, `fault` is high exactly when `fault_code` is nonzero.
- R2: Descriptor byte k sits in `desc_bytes[8k+7:8k]`. Bytes 0 and 1 form limit[15:0] (byte 0 low). Bytes 2, 3 and 4 form base[23:0]. Byte 5 is the rights byte. Byte 6 holds limit[19:16] in bits 3:0 and the flags in bits 7:4, with bit 7 as granularity. Byte 7 is base[31:24]. In the rights byte, bit 7 is present, bit 4 is code/data (1) versus system (0), bit 3 is executable, bit 2 is direction/conforming, bit 1 is writable (data) or readable (code), and bit 0 is accessed.
- R3: With `desc_wide` low (16-bit descriptor), bytes 6 and 7 are ignored. The base is then bytes 2 to 4 with zero above, the limit is bytes 0 and 1, and granularity is byte granular.
- R4: In protected mode, the linear address is base plus offset, modulo 2^32.
- R5: With granularity set, the effective limit is the 20-bit limit followed by twelve one bits. With it clear, the effective limit is the 20-bit limit counted in bytes.
- R6: For a data segment (executable clear) with the direction bit set, the offset must be strictly greater than the effective limit. For every other segment, including a code segment with the conforming bit set, the offset must not exceed the effective limit. A violation gives fault code 4.
- R7: In protected mode, a descriptor whose present bit is clear faults with code 1 for every access kind.
- R8: In protected mode, a present descriptor with the code/data bit clear faults with code 2.
- R9: Access kinds are 0 read, 1 write, 2 execute and 3 reserved. A rights fault (code 3) is raised for any of these: a write to a code segment; a write to a data segment whose writable bit is clear; a read of a code segment whose readable bit is clear; an execute from a data segment; or the reserved kind.
- R10: When more than one fault applies, the code is the first of: not-present (1), system (2), rights (3), limit (4). Code 0 means no fault.
- R11: In real mode, the linear address is the segment value times 16 plus the offset. An offset above 0xFFFF faults with code 4. The descriptor and the access kind have no effect, and `set_accessed` stays low.
- R12: In protected mode, `set_accessed` is high in the response exactly when the access completes without a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| prot_mode | input | 1 | 1 protected mode, 0 real mode |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| seg_value | input | 16 | Segment register value, used in real mode |
| desc_bytes | input | 64 | Descriptor, byte k in bits 8k+7:8k |
| desc_wide | input | 1 | 1 for a 32-bit descriptor, 0 for a 16-bit one |
| offset | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access refused |
| fault_code | output | 3 | 0 none, 1 not present, 2 system, 3 rights, 4 limit |
| set_accessed | output | 1 | Request to set the descriptor's accessed bit |

## Verification
The properties assume that every input is stable and known around the rising edge at which `req_valid` is sampled. They also assume that `desc_bytes` carries a real descriptor image only when `prot_mode` is high. In real mode the descriptor is don't-care.

The bench drives all inputs together on the falling edge, so one request is described by a single set of values. It holds `req_valid` low between table entries, so the idle-cycle properties see quiet cycles as well as requests. Some real-mode requests deliberately carry an absent descriptor, to show that the protected-mode fault paths stay out of the result.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  localparam int ADDR_W     = 32;
  localparam int LIM_W      = 20;
  localparam int SEG_W      = 16;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int PAGE_BITS  = 12;
  localparam int REAL_SHIFT = 4;
  localparam int CODE_W     = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [CODE_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_SYSTEM = 3'd2,
    FLT_RIGHTS = 3'd3,
    FLT_LIMIT  = 3'd4
  } flt_code_e;

  // rights byte, bit 7 down to bit 0
  typedef struct packed {
    logic       present;
    logic [1:0] ring;
    logic       code_data;
    logic       exec;
    logic       dir_conf;
    logic       rw;
    logic       touched;
  } rights_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              big;
    rights_t           rights;
  } seg_fields_t;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import segchk_pkg::*;
(
  input  logic [DESC_W-1:0] desc_bytes,
  input  logic              desc_wide,
  output seg_fields_t       fields
);

  logic [7:0] byte_q [DESC_BYTES];

  for (genvar gi = 0; gi < DESC_BYTES; gi++) begin : g_split
    assign byte_q[gi] = desc_bytes[8*gi +: 8];
  end

  logic [7:0] hi_base;
  logic [7:0] flag_lim;

  always_comb begin
    hi_base  = desc_wide ? byte_q[7] : 8'h00;
    flag_lim = desc_wide ? byte_q[6] : 8'h00;
    fields.base   = {hi_base, byte_q[4], byte_q[3], byte_q[2]};
    fields.limit  = {flag_lim[3:0], byte_q[1], byte_q[0]};
    fields.gran   = flag_lim[7];
    fields.big    = flag_lim[6];
    fields.rights = rights_t'(byte_q[5]);
  end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int ADDR_W    = 32,
  parameter int LIM_W     = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic [LIM_W-1:0]  limit,
  input  logic              gran,
  input  logic              expand_down,
  input  logic [ADDR_W-1:0] offset,
  output logic              in_range
);

  localparam int SCALED_W = LIM_W + PAGE_BITS;
  localparam int CMP_W    = (SCALED_W > ADDR_W) ? SCALED_W : ADDR_W;

  logic [SCALED_W-1:0] scaled;
  logic [CMP_W-1:0]    eff_lim;
  logic [CMP_W-1:0]    off_ext;

  always_comb begin
    if (gran) scaled = {limit, {PAGE_BITS{1'b1}}};
    else      scaled = {{PAGE_BITS{1'b0}}, limit};
    eff_lim = CMP_W'(scaled);
    off_ext = CMP_W'(offset);
    if (expand_down) in_range = (off_ext > eff_lim);
    else             in_range = (off_ext <= eff_lim);
  end

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import segchk_pkg::*;
(
  input  rights_t    rights,
  input  acc_kind_e  kind,
  output logic       absent,
  output logic       system_seg,
  output logic       denied
);

  always_comb begin
    absent     = !rights.present;
    system_seg = !rights.code_data;
    denied     = 1'b0;
    unique case (kind)
      ACC_READ:  denied = rights.exec && !rights.rw;
      ACC_WRITE: denied = rights.exec || !rights.rw;
      ACC_EXEC:  denied = !rights.exec;
      ACC_RSVD:  denied = 1'b1;
    endcase
  end

endmodule

// File: rtl/seg_fault_prio.sv
module seg_fault_prio
  import segchk_pkg::*;
(
  input  logic      absent,
  input  logic      system_seg,
  input  logic      denied,
  input  logic      over_limit,
  output flt_code_e code
);

  always_comb begin
    if (absent)          code = FLT_ABSENT;
    else if (system_seg) code = FLT_SYSTEM;
    else if (denied)     code = FLT_RIGHTS;
    else if (over_limit) code = FLT_LIMIT;
    else                 code = FLT_NONE;
  end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
  import segchk_pkg::*;
#(
  parameter logic [LIM_W-1:0] REAL_LIMIT = 20'h0FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              prot_mode,
  input  logic [1:0]        acc_kind,
  input  logic [SEG_W-1:0]  seg_value,
  input  logic [DESC_W-1:0] desc_bytes,
  input  logic              desc_wide,
  input  logic [ADDR_W-1:0] offset,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              fault,
  output logic [CODE_W-1:0] fault_code,
  output logic              set_accessed
);

  localparam int REAL_PAD = ADDR_W - SEG_W - REAL_SHIFT;

  seg_fields_t fld;
  logic        p_absent, p_system, p_denied;
  logic        lim_ok;
  flt_code_e   code_c;

  logic [ADDR_W-1:0] base_sel;
  logic [LIM_W-1:0]  lim_sel;
  logic              gran_sel;
  logic              down_sel;

  seg_desc_unpack u_unpack (
    .desc_bytes (desc_bytes),
    .desc_wide  (desc_wide),
    .fields     (fld)
  );

  seg_rights_check u_rights (
    .rights     (fld.rights),
    .kind       (acc_kind_e'(acc_kind)),
    .absent     (p_absent),
    .system_seg (p_system),
    .denied     (p_denied)
  );

  always_comb begin
    if (prot_mode) begin
      base_sel = fld.base;
      lim_sel  = fld.limit;
      gran_sel = fld.gran;
      down_sel = !fld.rights.exec && fld.rights.dir_conf;
    end else begin
      base_sel = {{REAL_PAD{1'b0}}, seg_value, {REAL_SHIFT{1'b0}}};
      lim_sel  = REAL_LIMIT;
      gran_sel = 1'b0;
      down_sel = 1'b0;
    end
  end

  seg_limit_check #(
    .ADDR_W    (ADDR_W),
    .LIM_W     (LIM_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_limit (
    .limit       (lim_sel),
    .gran        (gran_sel),
    .expand_down (down_sel),
    .offset      (offset),
    .in_range    (lim_ok)
  );

  seg_fault_prio u_prio (
    .absent     (prot_mode && p_absent),
    .system_seg (prot_mode && p_system),
    .denied     (prot_mode && p_denied),
    .over_limit (!lim_ok),
    .code       (code_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      lin_addr     <= '0;
      fault        <= 1'b0;
      fault_code   <= '0;
      set_accessed <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        lin_addr     <= base_sel + offset;
        fault        <= (code_c != FLT_NONE);
        fault_code   <= code_c;
        set_accessed <= prot_mode && (code_c == FLT_NONE);
      end else begin
        fault        <= 1'b0;
        set_accessed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seg_access_checker_sva.sv
module seg_access_checker_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        prot_mode,
  input logic [1:0]  acc_kind,
  input logic [15:0] seg_value,
  input logic [63:0] desc_bytes,
  input logic [31:0] offset,
  input logic        rsp_valid,
  input logic [31:0] lin_addr,
  input logic        fault,
  input logic [2:0]  fault_code,
  input logic        set_accessed
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !fault && !set_accessed)); // R1

  AST_FAULT_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (fault == (fault_code != 3'd0))); // R1

  AST_ABSENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_mode && !desc_bytes[47]) |=> (fault && fault_code == 3'd1)); // R7

  AST_SYSTEM_SEG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_mode && desc_bytes[47] && !desc_bytes[44])
      |=> (fault && fault_code == 3'd2)); // R8

  AST_CODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_mode && desc_bytes[47] && desc_bytes[44] && desc_bytes[43]
      && acc_kind == 2'd1) |=> (fault && fault_code == 3'd3)); // R9

  AST_REAL_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_mode)
      |=> (lin_addr == (({16'h0000, $past(seg_value)} << 4) + $past(offset)))); // R11

  AST_REAL_NO_TOUCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_mode) |=> !set_accessed); // R11

  AST_TOUCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    set_accessed |-> (rsp_valid && !fault)); // R12

endmodule

bind seg_access_checker seg_access_checker_sva u_sva (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .prot_mode    (prot_mode),
  .acc_kind     (acc_kind),
  .seg_value    (seg_value),
  .desc_bytes   (desc_bytes),
  .offset       (offset),
  .rsp_valid    (rsp_valid),
  .lin_addr     (lin_addr),
  .fault        (fault),
  .fault_code   (fault_code),
  .set_accessed (set_accessed)
);

// File: tb/tb_seg_access_checker.sv
`timescale 1ns/1ps
module tb_seg_access_checker;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        prot_mode;
  logic [1:0]  acc_kind;
  logic [15:0] seg_value;
  logic [63:0] desc_bytes;
  logic        desc_wide;
  logic [31:0] offset;
  logic        rsp_valid;
  logic [31:0] lin_addr;
  logic        fault;
  logic [2:0]  fault_code;
  logic        set_accessed;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  seg_access_checker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .prot_mode(prot_mode),
    .acc_kind(acc_kind), .seg_value(seg_value), .desc_bytes(desc_bytes),
    .desc_wide(desc_wide), .offset(offset), .rsp_valid(rsp_valid),
    .lin_addr(lin_addr), .fault(fault), .fault_code(fault_code),
    .set_accessed(set_accessed)
  );

  typedef struct packed {
    logic        prot;
    logic        wide;
    logic [1:0]  kind;
    logic [15:0] seg;
    logic [63:0] desc;
    logic [31:0] off;
    logic [31:0] lin;
    logic        flt;
    logic [2:0]  code;
    logic        acc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    // R2 R4 data rw, base 12345678, byte limit FFF
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h1240923456780FFF, 32'h00000100, 32'h12345778, 1'b0, 3'd0, 1'b1, 8'd2},
    // R6 expand-up: offset equal to limit passes
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h1240923456780FFF, 32'h00000FFF, 32'h12346677, 1'b0, 3'd0, 1'b1, 8'd6},
    // R6 one past the limit
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h1240923456780FFF, 32'h00001000, 32'h12346678, 1'b1, 3'd4, 1'b0, 8'd6},
    // R5 page granular, last byte of last page
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h12C0923456780FFF, 32'h00FFFFFF, 32'h13345677, 1'b0, 3'd0, 1'b1, 8'd5},
    // R5 first byte beyond
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h12C0923456780FFF, 32'h01000000, 32'h13345678, 1'b1, 3'd4, 1'b0, 8'd5},
    // R6 expand-down: offset equal to limit faults
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h0040960000000FFF, 32'h00000FFF, 32'h00000FFF, 1'b1, 3'd4, 1'b0, 8'd6},
    // R6 expand-down: limit plus one passes
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h0040960000000FFF, 32'h00001000, 32'h00001000, 1'b0, 3'd0, 1'b1, 8'd6},
    // R6 expand-down: top offset passes
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h0040960000000FFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 3'd0, 1'b1, 8'd6},
    // R12 execute from readable code
    '{1'b1, 1'b1, 2'd2, 16'h0, 64'h00CF9A010000FFFF, 32'h00001234, 32'h00011234, 1'b0, 3'd0, 1'b1, 8'd12},
    // R9 write to code
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h00CF9A010000FFFF, 32'h00001234, 32'h00011234, 1'b1, 3'd3, 1'b0, 8'd9},
    // R4 address wraps modulo 2^32
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h00CF9A010000FFFF, 32'hFFFF0000, 32'h00000000, 1'b0, 3'd0, 1'b1, 8'd4},
    // R9 read of execute-only code
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h00CF98010000FFFF, 32'h00000000, 32'h00010000, 1'b1, 3'd3, 1'b0, 8'd9},
    // R9 write to read-only data
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h004090000000FFFF, 32'h00000010, 32'h00000010, 1'b1, 3'd3, 1'b0, 8'd9},
    // R9 execute from data
    '{1'b1, 1'b1, 2'd2, 16'h0, 64'h004090000000FFFF, 32'h00000010, 32'h00000010, 1'b1, 3'd3, 1'b0, 8'd9},
    // R10 rights reported before limit
    '{1'b1, 1'b1, 2'd1, 16'h0, 64'h004090000000FFFF, 32'h00020000, 32'h00020000, 1'b1, 3'd3, 1'b0, 8'd10},
    // R12 read of read-only data
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h004090000000FFFF, 32'h00000010, 32'h00000010, 1'b0, 3'd0, 1'b1, 8'd12},
    // R9 reserved access kind
    '{1'b1, 1'b1, 2'd3, 16'h0, 64'h1240923456780FFF, 32'h00000000, 32'h12345678, 1'b1, 3'd3, 1'b0, 8'd9},
    // R7 not present, also beyond limit
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h004012000000FFFF, 32'h00020000, 32'h00020000, 1'b1, 3'd1, 1'b0, 8'd7},
    // R8 present system segment
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h004082000000FFFF, 32'h00000000, 32'h00000000, 1'b1, 3'd2, 1'b0, 8'd8},
    // R10 absent system segment reports absent
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h004002000000FFFF, 32'h00000000, 32'h00000000, 1'b1, 3'd1, 1'b0, 8'd10},
    // R10 system reported before limit
    '{1'b1, 1'b1, 2'd0, 16'h0, 64'h004082000000FFFF, 32'h00020000, 32'h00020000, 1'b1, 3'd2, 1'b0, 8'd10},
    // R3 16-bit descriptor, junk top bytes ignored
    '{1'b1, 1'b0, 2'd0, 16'h0, 64'hFFFF923456780FFF, 32'h00000FFF, 32'h00346677, 1'b0, 3'd0, 1'b1, 8'd3},
    // R3 byte granular despite junk granularity bit
    '{1'b1, 1'b0, 2'd0, 16'h0, 64'hFFFF923456780FFF, 32'h00001000, 32'h00346678, 1'b1, 3'd4, 1'b0, 8'd3},
    // R11 real mode, absent descriptor ignored
    '{1'b0, 1'b1, 2'd1, 16'hB800, 64'h004012000000FFFF, 32'h00000010, 32'h000B8010, 1'b0, 3'd0, 1'b0, 8'd11},
    // R11 real mode past 64K
    '{1'b0, 1'b1, 2'd0, 16'hB800, 64'h004012000000FFFF, 32'h00010000, 32'h000C8000, 1'b1, 3'd4, 1'b0, 8'd11},
    // R11 real mode top of segment, reserved kind not checked
    '{1'b0, 1'b1, 2'd3, 16'hFFFF, 64'h004082000000FFFF, 32'h0000FFFF, 32'h0010FFEF, 1'b0, 3'd0, 1'b0, 8'd11},
    // R6 conforming code is not expand-down
    '{1'b1, 1'b1, 2'd2, 16'h0, 64'h00409E0000000FFF, 32'h00000010, 32'h00000010, 1'b0, 3'd0, 1'b1, 8'd6}
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic idle_inputs();
    req_valid  = 1'b0;
    prot_mode  = 1'b1;
    acc_kind   = 2'd0;
    seg_value  = 16'h0;
    desc_bytes = 64'h0;
    desc_wide  = 1'b1;
    offset     = 32'h0;
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk(1, "lin_addr after reset", lin_addr, 32'd0);
    chk(1, "fault after reset", {31'b0, fault}, 32'd0);
    chk(1, "set_accessed after reset", {31'b0, set_accessed}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      req_valid  = 1'b1;
      prot_mode  = VECS[i].prot;
      desc_wide  = VECS[i].wide;
      acc_kind   = VECS[i].kind;
      seg_value  = VECS[i].seg;
      desc_bytes = VECS[i].desc;
      offset     = VECS[i].off;
      @(negedge clk);
      req_valid = 1'b0;
      chk(1, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      chk(VECS[i].req, "lin_addr", lin_addr, VECS[i].lin);
      chk(VECS[i].req, "fault", {31'b0, fault}, {31'b0, VECS[i].flt});
      chk(VECS[i].req, "fault_code", {29'b0, fault_code}, {29'b0, VECS[i].code});
      chk(12, "set_accessed", {31'b0, set_accessed}, {31'b0, VECS[i].acc});
      @(negedge clk);
    end

    // R1 idle cycle after a faulting request clears the strobes
    req_valid = 1'b1; prot_mode = 1'b1; acc_kind = 2'd0;
    desc_bytes = 64'h004012000000FFFF; offset = 32'h0;
    @(negedge clk);
    chk(1, "fault on request", {31'b0, fault}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(1, "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    chk(1, "fault idle", {31'b0, fault}, 32'd0);

    // R12 back-to-back requests, each answered one cycle later
    req_valid = 1'b1; desc_bytes = 64'h1240923456780FFF; offset = 32'h8;
    @(negedge clk);
    chk(12, "b2b first set_accessed", {31'b0, set_accessed}, 32'd1);
    desc_bytes = 64'h004082000000FFFF;
    @(negedge clk);
    chk(8, "b2b second code", {29'b0, fault_code}, 32'd2);
    chk(12, "b2b second set_accessed", {31'b0, set_accessed}, 32'd0);

    // R1 reset during a request
    desc_bytes = 64'h1240923456780FFF; rst = 1'b1;
    @(negedge clk);
    chk(1, "rsp_valid under reset", {31'b0, rsp_valid}, 32'd0);
    chk(1, "set_accessed under reset", {31'b0, set_accessed}, 32'd0);
    rst = 1'b0; idle_inputs();
    @(negedge clk);

    finish_run();
  end

endmodule